// File: doc/BRIEF.md
# Selectable Manchester / NRZI Line Codec

This block pairs a line encoder and a line decoder that share one mode control. With the mode low, both halves use Manchester coding. Each data bit takes two half-bit slots. The line level equals the data bit XORed with a bit-rate phase that is high in the first slot. With the mode high, both halves use NRZI coding. The line level flips for a data 1 and holds for a data 0.

The encoder is fed one bit per bit period through a bit strobe. A half-bit strobe moves it into the second slot and then back to idle. The decoder is given line samples at half-bit rate, with a flag that marks the first-slot sample. On each second-slot sample it produces a decoded bit. A Manchester symbol whose two halves carry the same level is reported as a symbol error and yields no valid bit.

Transmitter and receiver are assumed to run on a common, bit-aligned timebase. Clock recovery is not part of this block. The active mode is captured while the block is in reset or idle, so a symbol is never split across two codings.

Top module: `line_codec`

## Requirements
- R1: In Manchester mode (`mode_sel`=0), an accepted data 0 drives `line_out` high in the first slot and low in the second. A data 1 drives it low, then high.
- R2: The encoder takes `tx_bit` only in a cycle with `bit_strobe`=1, and the first slot appears on `line_out` the cycle after that edge. A `half_strobe` advances to the second slot, and a further `half_strobe` with no new strobe returns to idle. Changes of `tx_bit` without `bit_strobe` have no effect. The idle Manchester line is 0.
- R3: In NRZI mode (`mode_sel`=1), `line_out` toggles on each accepted data 1 and holds its level on an accepted data 0, in both slots of the bit.
- R4: In Manchester mode, a first-slot sample (`rx_sample`=1, `rx_first`=1) followed by a second-slot sample (`rx_sample`=1, `rx_first`=0) decodes low-then-high as 1 and high-then-low as 0.
- R5: In Manchester mode, equal first and second levels raise `symbol_error` for one cycle, with `bit_valid` low for that symbol.
- R6: In NRZI mode, each second-slot sample decodes to 1 when `line_in` differs from the previous bit's level, and to 0 when it is the same.
- R7: `bit_valid` is a one-cycle pulse in the cycle after the edge that takes a good second-slot sample.
- R8: The active-low synchronous reset clears `line_out`, `bit_valid` and `symbol_error`. It also sets the NRZI line level and the decoder's remembered level to 0.
- R9: A new `mode_sel` value is taken only in reset, or while the encoder has no bit in progress and the decoder holds no pending first-slot sample. A change made mid-symbol does not alter that symbol.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_sel | input | 1 | Coding select: 0 Manchester, 1 NRZI |
| half_strobe | input | 1 | Half-bit slot advance for the encoder |
| bit_strobe | input | 1 | Accept `tx_bit` as a new bit |
| tx_bit | input | 1 | Data bit to encode |
| line_out | output | 1 | Encoded line level |
| line_in | input | 1 | Received line level |
| rx_sample | input | 1 | Take a line sample this cycle |
| rx_first | input | 1 | Marks the sample as the first slot of a bit |
| rx_bit | output | 1 | Last decoded data bit |
| bit_valid | output | 1 | One-cycle pulse: `rx_bit` is new |
| symbol_error | output | 1 | One-cycle pulse: illegal Manchester symbol |

## Verification
The hardest case to reach from the ports is a change of `mode_sel` in the middle of a symbol. The gate that protects each symbol only acts in that window. The stimulus starts a Manchester data 1 and raises the mode input between the two slots. The second slot must still read high, and only later, once the block is idle, may NRZI levels appear. On the receive side, a first-slot sample is taken and the mode is flipped before an equal-level second sample. That sample must still be flagged as a Manchester symbol error rather than decoded as NRZI.

// File: rtl/line_codec.sv
module line_codec (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_sel,
  input  logic half_strobe,
  input  logic bit_strobe,
  input  logic tx_bit,
  output logic line_out,
  input  logic line_in,
  input  logic rx_sample,
  input  logic rx_first,
  output logic rx_bit,
  output logic bit_valid,
  output logic symbol_error
);

  logic mode_q;
  logic enc_active, enc_phase, enc_bit, nrzi_lvl;
  logic rx_pend, rx_half1, rx_prev;
  logic quiet;

  assign quiet = !enc_active && !rx_pend && !bit_strobe && !(rx_sample && rx_first);

  always_ff @(posedge clk) begin
    if (!rst_n || quiet) mode_q <= mode_sel;
  end

  // encoder
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      enc_active <= 1'b0;
      enc_phase  <= 1'b0;
      enc_bit    <= 1'b0;
      nrzi_lvl   <= 1'b0;
    end else if (bit_strobe) begin
      enc_active <= 1'b1;
      enc_phase  <= 1'b0;
      enc_bit    <= tx_bit;
      if (mode_q) nrzi_lvl <= nrzi_lvl ^ tx_bit;
    end else if (half_strobe && enc_active) begin
      if (!enc_phase) enc_phase <= 1'b1;
      else begin
        enc_active <= 1'b0;
        enc_phase  <= 1'b0;
      end
    end
  end

  assign line_out = mode_q ? nrzi_lvl : (enc_active & (enc_bit ^ ~enc_phase));

  // decoder
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_pend      <= 1'b0;
      rx_half1     <= 1'b0;
      rx_prev      <= 1'b0;
      rx_bit       <= 1'b0;
      bit_valid    <= 1'b0;
      symbol_error <= 1'b0;
    end else begin
      bit_valid    <= 1'b0;
      symbol_error <= 1'b0;
      if (rx_sample && rx_first) begin
        rx_pend  <= 1'b1;
        rx_half1 <= line_in;
      end else if (rx_sample) begin
        rx_pend <= 1'b0;
        if (mode_q) begin
          rx_bit    <= line_in ^ rx_prev;
          rx_prev   <= line_in;
          bit_valid <= 1'b1;
        end else if (rx_pend) begin
          if (line_in == rx_half1) symbol_error <= 1'b1;
          else begin
            rx_bit    <= line_in;
            bit_valid <= 1'b1;
          end
        end
      end
    end
  end

  assert_manch_halves_differ_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_q && enc_active && enc_phase && $past(enc_active && !enc_phase)) |-> line_out != $past(line_out));

  assert_nrzi_toggle_only_on_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q && $past(mode_q) && $past(rst_n) && line_out != $past(line_out)) |-> $past(bit_strobe && tx_bit));

  assert_error_from_manch_second_R5: assert property (@(posedge clk) disable iff (!rst_n)
    symbol_error |-> ($past(rx_sample && !rx_first && !mode_q && rx_pend) && !bit_valid));

  assert_valid_after_second_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bit_valid |-> $past(rx_sample && !rx_first));

  assert_mode_frozen_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (enc_active || rx_pend) |=> mode_q == $past(mode_q));

endmodule

// File: tb/line_codec_test.sv
`timescale 1ns/1ps
module line_codec_test;
  logic clk = 1'b0;
  logic rst_n, mode_sel, half_strobe, bit_strobe, tx_bit, line_in, rx_sample, rx_first;
  logic line_out, rx_bit, bit_valid, symbol_error;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  line_codec uut (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .half_strobe(half_strobe),
    .bit_strobe(bit_strobe), .tx_bit(tx_bit), .line_out(line_out), .line_in(line_in),
    .rx_sample(rx_sample), .rx_first(rx_first), .rx_bit(rx_bit), .bit_valid(bit_valid),
    .symbol_error(symbol_error));

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic check(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic enc_bit(logic b, logic e1, logic e2, string tag);
    bit_strobe = 1'b1; tx_bit = b; half_strobe = 1'b1;
    tick();
    bit_strobe = 1'b0; half_strobe = 1'b0;
    check({tag, " first slot"}, line_out, e1);
    half_strobe = 1'b1;
    tick();
    half_strobe = 1'b0;
    check({tag, " second slot"}, line_out, e2);
  endtask

  task automatic end_bit();
    half_strobe = 1'b1; tick(); half_strobe = 1'b0;
  endtask

  task automatic rx_sym(logic a, logic b, logic exp_valid, logic exp_bit, logic exp_err, string tag);
    line_in = a; rx_sample = 1'b1; rx_first = 1'b1;
    tick();
    check({tag, " R7 no valid after first"}, bit_valid, 1'b0);
    line_in = b; rx_first = 1'b0;
    tick();
    rx_sample = 1'b0;
    check({tag, " valid"}, bit_valid, exp_valid);
    check({tag, " error"}, symbol_error, exp_err);
    if (exp_valid) check({tag, " bit"}, rx_bit, exp_bit);
    tick();
    check({tag, " R7 valid pulse ends"}, bit_valid, 1'b0);
    check({tag, " R5 error pulse ends"}, symbol_error, 1'b0);
  endtask

  task automatic t_reset(logic m);
    rst_n = 1'b0; mode_sel = m;
    half_strobe = 0; bit_strobe = 0; tx_bit = 0; line_in = 0; rx_sample = 0; rx_first = 0;
    tick(); tick();
    check("R8 reset line_out", line_out, 1'b0);
    check("R8 reset bit_valid", bit_valid, 1'b0);
    check("R8 reset symbol_error", symbol_error, 1'b0);
    rst_n = 1'b1;
    tick();
  endtask

  task automatic t_manch_enc();
    t_reset(1'b0);
    enc_bit(1'b0, 1'b1, 1'b0, "R1 bit0");
    enc_bit(1'b1, 1'b0, 1'b1, "R1 bit1");
    enc_bit(1'b1, 1'b0, 1'b1, "R1 bit1 again");
    enc_bit(1'b0, 1'b1, 1'b0, "R1 bit0 again");
    end_bit();
    check("R2 idle after last bit", line_out, 1'b0);
  endtask

  task automatic t_strobe_ignore();
    t_reset(1'b0);
    for (int i = 0; i < 4; i++) begin
      tx_bit = i[0]; half_strobe = 1'b1; tick();
      check("R2 no strobe no output", line_out, 1'b0);
    end
    half_strobe = 1'b0;
    bit_strobe = 1'b1; tx_bit = 1'b1; tick(); bit_strobe = 1'b0;
    check("R2 strobed bit1 first slot", line_out, 1'b0);
    tx_bit = 1'b0; tick();
    check("R2 tx_bit change ignored", line_out, 1'b0);
    half_strobe = 1'b1; tick(); half_strobe = 1'b0;
    check("R2 kept bit1 second slot", line_out, 1'b1);
    end_bit();
  endtask

  task automatic t_nrzi_enc();
    t_reset(1'b1);
    enc_bit(1'b1, 1'b1, 1'b1, "R3 one toggles");
    enc_bit(1'b0, 1'b1, 1'b1, "R3 zero holds");
    enc_bit(1'b1, 1'b0, 1'b0, "R3 one toggles down");
    enc_bit(1'b1, 1'b1, 1'b1, "R3 one toggles up");
    end_bit();
    check("R3 idle holds level", line_out, 1'b1);
  endtask

  task automatic t_manch_dec();
    t_reset(1'b0);
    rx_sym(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, "R4 low-high");
    rx_sym(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "R4 high-low");
    rx_sym(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, "R5 high-high");
    rx_sym(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R5 low-low");
    rx_sym(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, "R4 recovers");
  endtask

  task automatic t_nrzi_dec();
    t_reset(1'b1);
    rx_sym(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R8 R6 level0 from reset");
    rx_sym(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, "R6 change");
    rx_sym(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, "R6 same");
    rx_sym(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, "R6 change down");
    rx_sym(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "R6 no error in nrzi");
  endtask

  task automatic t_mode_switch();
    t_reset(1'b0);
    bit_strobe = 1'b1; tx_bit = 1'b1; tick(); bit_strobe = 1'b0;
    check("R9 manch first slot", line_out, 1'b0);
    mode_sel = 1'b1;
    half_strobe = 1'b1; tick(); half_strobe = 0;
    check("R9 mid-bit switch ignored", line_out, 1'b1);
    end_bit();
    tick(); tick();
    check("R9 nrzi level after idle", line_out, 1'b0);
    enc_bit(1'b1, 1'b1, 1'b1, "R9 nrzi now active");
    end_bit();
    mode_sel = 1'b0; tick(); tick();
    check("R9 back to manch idle", line_out, 1'b0);
    line_in = 1'b1; rx_sample = 1'b1; rx_first = 1'b1; tick();
    mode_sel = 1'b1; rx_first = 1'b0; tick(); rx_sample = 1'b0;
    check("R9 rx switch ignored error", symbol_error, 1'b1);
    check("R9 rx switch ignored valid", bit_valid, 1'b0);
    tick(); tick();
    rx_sym(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, "R9 rx nrzi after idle");
  endtask

  initial begin
    @(negedge clk);
    t_manch_enc();
    t_strobe_ignore();
    t_nrzi_enc();
    t_manch_dec();
    t_nrzi_dec();
    t_mode_switch();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule